// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Status

This block provides two programmable up-counting interval timers that share one interrupt status byte. Each timer has its own preload register. Once started, a timer counts up from its preload. When it passes its all-ones value it reloads the preload and keeps running, and it reports that overflow as a sticky flag in the status byte. The fast timer advances once per base tick. The slow timer advances once every `SLOW_RATIO` base ticks. The base tick comes from the system clock through a prescaler of `CLKS_PER_TICK` cycles.

Software uses a single control byte to start or stop each timer, to mask each timer's flag, and to clear all flags. A clear request takes priority over every other bit written with it. The interrupt output follows the summary bit of the status byte.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset the status byte and `irq` are 0 and both timers are stopped.
- R2: A running fast timer advances once every `CLKS_PER_TICK` clocks. From preload P it overflows every (256 - P) base ticks.
- R3: A running slow timer advances once every `SLOW_RATIO` base ticks. With preload FFh it overflows every `SLOW_RATIO * CLKS_PER_TICK` clocks.
- R4: On overflow a running timer reloads its preload and keeps counting without software action.
- R5: Control bit 0 runs the fast timer and bit 1 runs the slow timer. A 0-to-1 change of a run bit loads the preload into the counter. A stopped timer never overflows.
- R6: Control bit 6 masks the fast timer's flag and bit 5 masks the slow timer's flag. A masked timer keeps counting but its overflow leaves its flag unchanged.
- R7: A control write with bit 7 set clears all three flags and leaves the run and mask settings unchanged. A clear written together with overflow in the same cycle still leaves the flags at 0.
- R8: Status bit 6 is the fast-timer flag and bit 5 is the slow-timer flag. Bit 7 is the OR of the two. Bits 4 to 0 read 0.
- R9: `irq` equals status bit 7 on every cycle.
- R10: A flag, once set, stays set until a clear write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_preload_a | input | 1 | Write strobe: `wr_data` into the fast-timer preload |
| wr_preload_b | input | 1 | Write strobe: `wr_data` into the slow-timer preload |
| wr_ctrl | input | 1 | Write strobe: `wr_data` into the control byte |
| wr_data | input | 8 | Write data shared by the three strobes |
| status | output | 8 | Flag byte {any, fast, slow, 00000} |
| irq | output | 1 | Interrupt level, equal to status bit 7 |

## Verification
The bench builds the block with `CLKS_PER_TICK = 4` and `SLOW_RATIO = 4`. A base tick then lasts four clocks and a slow tick sixteen. With these values full reload periods, slow-timer overflows and clears that coincide with an overflow all occur within a few hundred cycles. At this scale the exact cycle of every flag change can be compared against a behavioural model on each clock. The measured gaps between overflows, 64 clocks for preload F0h and 16 clocks for the slow timer at FFh, fall directly out of these two parameters.

// File: rtl/dit_pkg.sv
package dit_pkg;

  localparam int BIT_RUN_A  = 0;
  localparam int BIT_RUN_B  = 1;
  localparam int BIT_MASK_B = 5;
  localparam int BIT_MASK_A = 6;
  localparam int BIT_CLEAR  = 7;

  typedef struct packed {
    logic run_a;
    logic run_b;
    logic mask_a;
    logic mask_b;
  } ctl_t;

  function automatic ctl_t decode_ctrl(input logic [7:0] d);
    ctl_t c;
    c.run_a  = d[BIT_RUN_A];
    c.run_b  = d[BIT_RUN_B];
    c.mask_a = d[BIT_MASK_A];
    c.mask_b = d[BIT_MASK_B];
    return c;
  endfunction

  function automatic logic is_clear(input logic [7:0] d);
    return d[BIT_CLEAR];
  endfunction

  function automatic logic [7:0] pack_status(input logic flag_a, input logic flag_b);
    return {flag_a | flag_b, flag_a, flag_b, 5'b00000};
  endfunction

endpackage

// File: rtl/dit_tick_gen.sv
module dit_tick_gen #(
  parameter int CLKS_PER_TICK = 4000,
  parameter int SLOW_RATIO    = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_fast,
  output logic tick_slow
);
  localparam int PW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam int SW = (SLOW_RATIO > 1) ? $clog2(SLOW_RATIO) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_TICK - 1);
  localparam logic [SW-1:0] DIV_LAST = SW'(SLOW_RATIO - 1);

  logic [PW-1:0] pre_q;
  logic [SW-1:0] div_q;

  assign tick_fast = (pre_q == PRE_LAST);
  assign tick_slow = tick_fast && (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= tick_fast ? '0 : pre_q + 1'b1;
      if (tick_fast)
        div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/dit_counter.sv
module dit_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             start,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign ovf = run && tick && !start && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (start)
      cnt <= preload;
    else if (run && tick)
      cnt <= (cnt == CNT_MAX) ? preload : cnt + 1'b1;
  end
endmodule

// File: rtl/dit_flags.sv
module dit_flags #(
  parameter int NT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [NT-1:0] ovf,
  input  logic [NT-1:0] mask,
  output logic [NT-1:0] flag
);
  for (genvar i = 0; i < NT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n || clear)
        flag[i] <= 1'b0;
      else if (ovf[i] && !mask[i])
        flag[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
  parameter int CNT_W         = 8,
  parameter int CLKS_PER_TICK = 4000,
  parameter int SLOW_RATIO    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_preload_a,
  input  logic       wr_preload_b,
  input  logic       wr_ctrl,
  input  logic [7:0] wr_data,
  output logic [7:0] status,
  output logic       irq
);
  import dit_pkg::*;

  localparam int NT = 2;

  ctl_t ctl_q;
  ctl_t ctl_new;
  logic ctrl_apply;
  logic clear_req;

  logic tick_fast, tick_slow;
  logic [NT-1:0] tick_v, run_v, new_run_v, start_v, mask_v, ovf_v, wr_pre_v, flag_v;
  logic [CNT_W-1:0] pre_q [NT];
  logic [CNT_W-1:0] cnt_v [NT];

  assign ctl_new    = decode_ctrl(wr_data);
  assign clear_req  = wr_ctrl && is_clear(wr_data);
  assign ctrl_apply = wr_ctrl && !is_clear(wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctl_q <= '0;
    else if (ctrl_apply)
      ctl_q <= ctl_new;
  end

  dit_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK), .SLOW_RATIO(SLOW_RATIO)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow)
  );

  assign tick_v    = {tick_slow, tick_fast};
  assign run_v     = {ctl_q.run_b, ctl_q.run_a};
  assign mask_v    = {ctl_q.mask_b, ctl_q.mask_a};
  assign new_run_v = {ctl_new.run_b, ctl_new.run_a};
  assign wr_pre_v  = {wr_preload_b, wr_preload_a};

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    assign start_v[i] = ctrl_apply && new_run_v[i] && !run_v[i];

    always_ff @(posedge clk) begin
      if (!rst_n)
        pre_q[i] <= '0;
      else if (wr_pre_v[i])
        pre_q[i] <= wr_data[CNT_W-1:0];
    end

    dit_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick_v[i]), .run(run_v[i]),
      .start(start_v[i]), .preload(pre_q[i]), .cnt(cnt_v[i]), .ovf(ovf_v[i])
    );
  end

  dit_flags #(.NT(NT)) u_flags (
    .clk(clk), .rst_n(rst_n), .clear(clear_req),
    .ovf(ovf_v), .mask(mask_v), .flag(flag_v)
  );

  assign status = pack_status(flag_v[0], flag_v[1]);
  assign irq    = status[7];

  // named internal events for the bound checker
  logic [CNT_W-1:0] cnt_a, cnt_b, preload_a, preload_b;
  logic ovf_a, ovf_b, start_a, start_b, mask_a, run_a, run_b;
  assign cnt_a     = cnt_v[0];
  assign cnt_b     = cnt_v[1];
  assign preload_a = pre_q[0];
  assign preload_b = pre_q[1];
  assign ovf_a     = ovf_v[0];
  assign ovf_b     = ovf_v[1];
  assign start_a   = start_v[0];
  assign start_b   = start_v[1];
  assign mask_a    = mask_v[0];
  assign run_a     = run_v[0];
  assign run_b     = run_v[1];
endmodule

// File: rtl/dit_checker.sv
module dit_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_ctrl,
  input logic [7:0]       wr_data,
  input logic [7:0]       status,
  input logic             irq,
  input logic             tick_fast,
  input logic             tick_slow,
  input logic [CNT_W-1:0] cnt_a,
  input logic [CNT_W-1:0] cnt_b,
  input logic [CNT_W-1:0] preload_a,
  input logic [CNT_W-1:0] preload_b,
  input logic             ovf_a,
  input logic             ovf_b,
  input logic             start_a,
  input logic             start_b,
  input logic             mask_a,
  input logic             run_a,
  input logic             run_b
);
  a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == status[7]);

  a_r8_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[4:0] == 5'b00000);

  a_r7_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wr_data[7]) |=> (status[7:5] == 3'b000));

  a_r7_clear_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wr_data[7]) |=> ($stable(run_a) && $stable(run_b)));

  a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_a && mask_a && !status[6] && !wr_ctrl) |=> !status[6]);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] && !(wr_ctrl && wr_data[7])) |=> status[6]);

  a_r4_reload_a: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_a |=> (cnt_a == $past(preload_a)));

  a_r4_reload_b: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_b |=> (cnt_b == $past(preload_b)));

  a_r5_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    start_a |=> (cnt_a == $past(preload_a)));

  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_fast && !start_a) |=> $stable(cnt_a));

  a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_slow && !start_b) |=> $stable(cnt_b));

  a_r3_slow_in_fast: assert property (@(posedge clk) disable iff (!rst_n)
    tick_slow |-> tick_fast);
endmodule

bind dual_interval_timer dit_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
  .status(status), .irq(irq), .tick_fast(tick_fast), .tick_slow(tick_slow),
  .cnt_a(cnt_a), .cnt_b(cnt_b), .preload_a(preload_a), .preload_b(preload_b),
  .ovf_a(ovf_a), .ovf_b(ovf_b), .start_a(start_a), .start_b(start_b),
  .mask_a(mask_a), .run_a(run_a), .run_b(run_b)
);

// File: tb/sim_dual_interval_timer.sv
`timescale 1ns/1ps
module sim_dual_interval_timer;
  localparam int N = 4;
  localparam int R = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_preload_a = 1'b0, wr_preload_b = 1'b0, wr_ctrl = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] status;
  logic irq;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_interval_timer #(.CNT_W(8), .CLKS_PER_TICK(N), .SLOW_RATIO(R)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_preload_a(wr_preload_a), .wr_preload_b(wr_preload_b),
    .wr_ctrl(wr_ctrl), .wr_data(wr_data), .status(status), .irq(irq)
  );

  // behavioural reference model
  int pc, dv, c1, c2, p1, p2;
  bit r1, r2, m1, m2, f1, f2;
  always @(posedge clk) begin
    bit ft, st, clr, s1, s2, o1, o2;
    cyc++;
    if (!rst_n) begin
      pc = 0; dv = 0; c1 = 0; c2 = 0; p1 = 0; p2 = 0;
      r1 = 0; r2 = 0; m1 = 0; m2 = 0; f1 = 0; f2 = 0;
    end else begin
      ft = (pc == N - 1);
      st = ft && (dv == R - 1);
      pc = ft ? 0 : pc + 1;
      if (ft) dv = (dv == R - 1) ? 0 : dv + 1;
      clr = wr_ctrl && wr_data[7];
      s1 = wr_ctrl && !wr_data[7] && wr_data[0] && !r1;
      s2 = wr_ctrl && !wr_data[7] && wr_data[1] && !r2;
      o1 = 0; o2 = 0;
      if (s1) c1 = p1;
      else if (r1 && ft) begin
        if (c1 == 255) begin c1 = p1; o1 = 1; end else c1 = c1 + 1;
      end
      if (s2) c2 = p2;
      else if (r2 && st) begin
        if (c2 == 255) begin c2 = p2; o2 = 1; end else c2 = c2 + 1;
      end
      if (clr) begin f1 = 0; f2 = 0; end
      else begin
        if (o1 && !m1) f1 = 1;
        if (o2 && !m2) f2 = 1;
      end
      if (wr_ctrl && !wr_data[7]) begin
        r1 = wr_data[0]; r2 = wr_data[1]; m1 = wr_data[6]; m2 = wr_data[5];
      end
      if (wr_preload_a) p1 = int'(wr_data);
      if (wr_preload_b) p2 = int'(wr_data);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model (R8, R9)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] exp_s;
      exp_s = {f1 | f2, f1, f2, 5'b00000};
      check(status == exp_s, "R8 model", int'(status), int'(exp_s));
      check(irq == status[7], "R9 irq", int'(irq), int'(status[7]));
    end
  end

  task automatic wr(input int sel, input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    wr_preload_a = (sel == 0);
    wr_preload_b = (sel == 1);
    wr_ctrl      = (sel == 2);
    @(negedge clk);
    wr_preload_a = 0; wr_preload_b = 0; wr_ctrl = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_bit(input int b, input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      if (status[b]) begin at = cyc; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    int t0, t1;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    check(status == 8'h00, "R1 status", int'(status), 0);
    check(irq == 1'b0, "R1 irq", int'(irq), 0);

    wr(2, 8'h60); wr(2, 8'h80);
    check(status[7:5] == 3'b000, "R7 clear", int'(status[7:5]), 0);

    wr(0, 8'hFF); wr(2, 8'h21);
    wait_bit(6, 30, t0);
    check(status == 8'hC0, "R2 first overflow", int'(status), 8'hC0);

    wr(2, 8'h80);
    check(status == 8'h00, "R7 clear while running", int'(status), 0);

    wr(2, 8'h00); wr(2, 8'h80); wr(0, 8'hF0); wr(2, 8'h01);
    wait_bit(6, 200, t0);
    wr(2, 8'h80);
    wait_bit(6, 200, t1);
    check(t1 - t0 == 16 * N, "R4 reload period", t1 - t0, 16 * N);

    wr(2, 8'h00); wr(2, 8'h80); wr(1, 8'hFF); wr(2, 8'h02);
    wait_bit(5, 100, t0);
    check(status == 8'hA0, "R8 slow flag layout", int'(status), 8'hA0);
    wr(2, 8'h80);
    wait_bit(5, 100, t1);
    check(t1 - t0 == R * N, "R3 slow period", t1 - t0, R * N);

    wr(2, 8'h00); wr(2, 8'h80); wr(0, 8'hFF); wr(2, 8'h41);
    idle(40);
    check(status == 8'h00, "R6 masked", int'(status), 0);
    wr(2, 8'h01);
    wait_bit(6, 30, t0);
    check(status[6] == 1'b1, "R6 counter kept running", int'(status[6]), 1);

    wr(2, 8'h00); wr(2, 8'h80); wr(1, 8'hFF); wr(2, 8'h83);
    idle(80);
    check(status == 8'h00, "R7 other bits ignored", int'(status), 0);

    wr(2, 8'h01);
    wait_bit(6, 30, t0);
    wr(2, 8'h00);
    idle(50);
    check(status == 8'hC0, "R10 sticky", int'(status), 8'hC0);
    wr(2, 8'h80);
    idle(50);
    check(status == 8'h00, "R5 stopped timer silent", int'(status), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule